// File: doc/BRIEF.md
# Dual-Memory Signal Pattern Sequencer

The block plays a stored pattern onto an 8-bit bus of timing signals, one word per clock, and records an 8-bit bus of the same signals into a second memory. Both memories have 2^ADDR_W entries of 8 bits. ADDR_W = 14 gives the full 16K-entry size; the default is smaller to keep elaboration light. A host port reads and writes both memories as one 16-bit word per index. The low byte is the playback (source) entry and the high byte is the capture (sink) entry. Host reads take one cycle.

The bit order is the same on the output bus, on the captured bus and inside both bytes: bit 0 trigger, bit 1 event-counter reset, bit 2 bunch-counter reset, bit 3 calibrate, bit 4 serial ID, bit 5 serial type, bit 6 front-end reset, bit 7 spare.

A run covers addresses 0 through `end_addr_i`. It either stops there or wraps to 0 when cyclic mode is set. The sink is started in one of two ways. A sink go starts both sides with the capture aligned to the playback. Or the sink is armed and starts on the next trigger seen on the captured bus.

Top module: `pattern_sequencer`

## Requirements
- R1: Host word index i reads as {sink[i], source[i]}: the sink entry is bits 15:8 and the source entry is bits 7:0. The data appears on `host_rdata_o` one clock after the address is presented. A write stores byte 0 only when `host_be_i[0]` is set and byte 1 only when `host_be_i[1]` is set.
- R2: On `sig_o`, on `sink_data_i` and in both bytes, bit 0 is trigger, bit 1 event reset, bit 2 bunch reset, bit 3 calibrate, bit 4 serial ID, bit 5 serial type, bit 6 front-end reset and bit 7 spare. The sink trigger uses bit 0 only.
- R3: Call C the first cycle in which `seq_go_i` is high after a low cycle. Source word 0 appears on `sig_o` in cycle C+2 and the following words appear one per clock. `src_run_o` is high in exactly the cycles that show a word.
- R4: Playback starts only on a low-to-high change of `seq_go_i` or `sink_go_i`. Holding go high never starts a second run. A go raised while `seq_rst_i` is high, and still high after it drops, starts nothing.
- R5: While `seq_rst_i` is high, the source is idle: from the next cycle `src_run_o` and `sig_o` are 0. Neither reset clears either memory.
- R6: With `cyclic_i` low, a run shows end+1 words and stops. With `cyclic_i` high, the address wraps from end to 0 and playback continues. Clearing `cyclic_i` ends the run at the next pass of the end address.
- R7: While `sink_rst_i` is high, the sink is idle: capture stops from that cycle, `sink_run_o` is 0 from the next cycle, and triggers are ignored.
- R8: Bit n of `sig_o` is 0 whenever `sig_en_i[n]` is 0, whatever the memory holds. `src_run_o` does not depend on the enables.
- R9: A rising `sink_go_i` starts the source as in R3, and it starts the sink. Sink entry k receives the `sink_data_i` value of the cycle in which source word k is on `sig_o`. The capture covers end+1 words, and `sink_run_o` is high for end+1 cycles.
- R10: When `sink_trig_en_i` is high and the sink is idle, a cycle with `sink_data_i[0]` high stores that cycle's bus value as sink entry 0. The bus values of the following cycles go to entries 1 to end. `sink_run_o` is high for the end+1 cycles after the trigger cycle. With `sink_trig_en_i` low, or with bit 0 low, no capture starts.
- R11: When a host write and a sink capture hit the same index in the same cycle, the capture data is stored in the high byte. The host's low byte is still written.
- R12: `rst_ni` clears the control state and leaves both memories unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset of control state |
| host_addr_i | input | ADDR_W | Host word index |
| host_we_i | input | 1 | Host write strobe |
| host_be_i | input | 2 | Byte enables: bit 0 source byte, bit 1 sink byte |
| host_wdata_i | input | 16 | Host write data |
| host_rdata_o | output | 16 | Registered host read data {sink, source} |
| end_addr_i | input | ADDR_W | Last address of a run |
| sig_en_i | input | 8 | Per-signal output enables |
| seq_rst_i | input | 1 | Holds the source idle |
| seq_go_i | input | 1 | Source start, rising change only |
| cyclic_i | input | 1 | Wrap at end address |
| sink_rst_i | input | 1 | Holds the sink idle |
| sink_go_i | input | 1 | Start sink and source, rising change only |
| sink_trig_en_i | input | 1 | Arm sink start on trigger bit |
| sink_data_i | input | 8 | Signal bus being recorded |
| sig_o | output | 8 | Gated playback signal bus |
| src_run_o | output | 1 | Playback words are being shown |
| sink_run_o | output | 1 | Capture in progress |

## Verification
The bench targets the end-address boundaries. At end 0 the run must show exactly one word, and at the last memory index it must not roll over. A cyclic run whose mode is cleared mid-run must stop on the end word; an off-by-one design would show one word too many or too few. Go held high, and go held through a sequencer reset, must not start a run, which a level-sensitive start would get wrong. The loopback capture checks the two-cycle source-to-sink alignment. A misaligned sink would store every word shifted by one index. A host write that collides with a capture must lose only the sink byte; a wrong priority would leave host data in the sink entry. A capture cut short by sink reset must stop without writing one more entry.

// File: rtl/pseq_pkg.sv
package pseq_pkg;
  localparam int SIG_W = 8;

  typedef enum logic [2:0] {
    SIG_TRIG     = 3'd0,
    SIG_EVT_RST  = 3'd1,
    SIG_BX_RST   = 3'd2,
    SIG_CAL      = 3'd3,
    SIG_SER_ID   = 3'd4,
    SIG_SER_TYPE = 3'd5,
    SIG_FE_RST   = 3'd6,
    SIG_SPARE    = 3'd7
  } sig_idx_e;

  typedef logic [SIG_W-1:0] sig_bus_t;
endpackage

// File: rtl/ps_rise_det.sv
module ps_rise_det #(
  parameter int W = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] in_i,
  output logic [W-1:0] rise_o
);
  logic [W-1:0] prev_q;

  // reset to ones: a level already high when reset ends is not an edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '1;
    else         prev_q <= in_i;
  end

  assign rise_o = in_i & ~prev_q;
endmodule

// File: rtl/ps_addr_gen.sv
module ps_addr_gen #(
  parameter int ADDR_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              start_i,
  input  logic              cyclic_i,
  input  logic [ADDR_W-1:0] end_i,
  output logic              run_o,
  output logic [ADDR_W-1:0] addr_o
);
  logic at_end;
  assign at_end = (addr_o == end_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_o  <= 1'b0;
      addr_o <= '0;
    end else if (clr_i) begin
      run_o  <= 1'b0;
      addr_o <= '0;
    end else if (start_i) begin
      run_o  <= 1'b1;
      addr_o <= '0;
    end else if (run_o) begin
      if (at_end) begin
        addr_o <= '0;
        run_o  <= cyclic_i;
      end else begin
        addr_o <= addr_o + 1'b1;
      end
    end
  end

  p_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_o && !at_end && !clr_i && !start_i) |=> (run_o && addr_o == $past(addr_o) + 1'b1));

  p_wrap_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_o && at_end && cyclic_i && !clr_i && !start_i) |=> (run_o && addr_o == '0));

  p_stop_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_o && at_end && !cyclic_i && !clr_i && !start_i) |=> !run_o);

  // shared by source (R5) and sink (R7)
  p_clr_idle_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !run_o);
endmodule

// File: rtl/ps_byte_mem.sv
module ps_byte_mem #(
  parameter int ADDR_W = 10,
  parameter int W      = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              a_we_i,
  input  logic [ADDR_W-1:0] a_addr_i,
  input  logic [W-1:0]      a_wdata_i,
  output logic [W-1:0]      a_rdata_o,
  input  logic              b_we_i,
  input  logic [ADDR_W-1:0] b_addr_i,
  input  logic [W-1:0]      b_wdata_i,
  output logic [W-1:0]      b_rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [W-1:0] mem_q [DEPTH];
  logic         b_blocked;

  assign b_blocked = a_we_i && (a_addr_i == b_addr_i);

  // no reset on storage; port a wins a same-index collision
  always_ff @(posedge clk_i) begin
    if (a_we_i)                mem_q[a_addr_i] <= a_wdata_i;
    if (b_we_i && !b_blocked)  mem_q[b_addr_i] <= b_wdata_i;
    a_rdata_o <= mem_q[a_addr_i];
    b_rdata_o <= mem_q[b_addr_i];
  end

  p_capture_wins_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (a_we_i && b_we_i && a_addr_i == b_addr_i) |=> (mem_q[$past(a_addr_i)] == $past(a_wdata_i)));
endmodule

// File: rtl/pattern_sequencer.sv
module pattern_sequencer
  import pseq_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] host_addr_i,
  input  logic              host_we_i,
  input  logic [1:0]        host_be_i,
  input  logic [15:0]       host_wdata_i,
  output logic [15:0]       host_rdata_o,
  input  logic [ADDR_W-1:0] end_addr_i,
  input  logic [7:0]        sig_en_i,
  input  logic              seq_rst_i,
  input  logic              seq_go_i,
  input  logic              cyclic_i,
  input  logic              sink_rst_i,
  input  logic              sink_go_i,
  input  logic              sink_trig_en_i,
  input  logic [7:0]        sink_data_i,
  output logic [7:0]        sig_o,
  output logic              src_run_o,
  output logic              sink_run_o
);
  localparam int SINK_LAG = 2;  // source word reaches sig_o two cycles after go

  logic [1:0]        go_rise;
  logic              src_start, src_run;
  logic [ADDR_W-1:0] src_addr;
  sig_bus_t          src_rd_a, src_rd_b;
  logic              out_act_q;

  logic [SINK_LAG-1:0] pend_q;
  logic              trig_start, snk_start, snk_run, snk_we;
  logic [ADDR_W-1:0] snk_addr;
  sig_bus_t          cap_q, snk_rd_b, snk_rd_unused;

  ps_rise_det #(.W(2)) u_go_rise (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .in_i   ({sink_go_i, seq_go_i}),
    .rise_o (go_rise)
  );

  // ---------------- source ----------------
  assign src_start = |go_rise;

  ps_addr_gen #(.ADDR_W(ADDR_W)) u_src_addr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (seq_rst_i),
    .start_i  (src_start),
    .cyclic_i (cyclic_i),
    .end_i    (end_addr_i),
    .run_o    (src_run),
    .addr_o   (src_addr)
  );

  ps_byte_mem #(.ADDR_W(ADDR_W), .W(SIG_W)) u_src_mem (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .a_we_i    (1'b0),
    .a_addr_i  (src_addr),
    .a_wdata_i ('0),
    .a_rdata_o (src_rd_a),
    .b_we_i    (host_we_i && host_be_i[0]),
    .b_addr_i  (host_addr_i),
    .b_wdata_i (host_wdata_i[7:0]),
    .b_rdata_o (src_rd_b)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        out_act_q <= 1'b0;
    else if (seq_rst_i) out_act_q <= 1'b0;
    else                out_act_q <= src_run;
  end

  assign src_run_o = out_act_q;
  assign sig_o     = out_act_q ? (src_rd_a & sig_en_i) : '0;

  // ---------------- sink ----------------
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      cap_q  <= '0;
    end else begin
      cap_q <= sink_data_i;
      if (sink_rst_i) pend_q <= '0;
      else            pend_q <= {pend_q[SINK_LAG-2:0], go_rise[1]};
    end
  end

  assign trig_start = sink_trig_en_i && !sink_rst_i && !snk_run && !(|pend_q)
                      && sink_data_i[SIG_TRIG];
  assign snk_start  = pend_q[SINK_LAG-1] || trig_start;
  assign snk_we     = snk_run && !sink_rst_i;

  ps_addr_gen #(.ADDR_W(ADDR_W)) u_snk_addr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (sink_rst_i),
    .start_i  (snk_start),
    .cyclic_i (cyclic_i),
    .end_i    (end_addr_i),
    .run_o    (snk_run),
    .addr_o   (snk_addr)
  );

  ps_byte_mem #(.ADDR_W(ADDR_W), .W(SIG_W)) u_snk_mem (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .a_we_i    (snk_we),
    .a_addr_i  (snk_addr),
    .a_wdata_i (cap_q),
    .a_rdata_o (snk_rd_unused),
    .b_we_i    (host_we_i && host_be_i[1]),
    .b_addr_i  (host_addr_i),
    .b_wdata_i (host_wdata_i[15:8]),
    .b_rdata_o (snk_rd_b)
  );

  assign sink_run_o   = snk_run;
  assign host_rdata_o = {snk_rd_b, src_rd_b};

  // ---------------- assertions ----------------
  p_go_edge_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(src_run) |-> (($past(seq_go_i) && !$past(seq_go_i, 2)) ||
                        ($past(sink_go_i) && !$past(sink_go_i, 2))));

  p_out_align_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(seq_rst_i) |-> (src_run_o == $past(src_run)));

  p_seq_idle_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seq_rst_i |=> (!src_run_o && sig_o == '0));

  p_sink_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sink_rst_i |=> !sink_run_o);

  p_trig_arm_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trig_start && !pend_q[SINK_LAG-1]) |=> (sink_run_o && snk_addr == '0));
endmodule

// File: tb/pattern_sequencer_bench.sv
`timescale 1ns/1ps
module pattern_sequencer_bench;
  localparam int AW = 4;
  localparam int N  = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic [AW-1:0] host_addr = '0;
  logic          host_we = 1'b0;
  logic [1:0]    host_be = 2'b00;
  logic [15:0]   host_wdata = '0;
  logic [15:0]   host_rdata_o;
  logic [AW-1:0] end_a = '0;
  logic [7:0]    sig_en = 8'hFF;
  logic          seq_rst = 1'b0, seq_go = 1'b0, cyc = 1'b0;
  logic          sink_rst = 1'b0, sink_go = 1'b0, trig_en = 1'b0;
  logic          loop_en = 1'b0;
  logic [7:0]    tb_bus = '0;
  logic [7:0]    sink_data, sig_o;
  logic          src_run_o, sink_run_o;

  logic [7:0] src_m [N];
  logic [7:0] snk_m [N];
  int n_cmp = 0, n_bad = 0;

  always #4 clk = ~clk;

  assign sink_data = loop_en ? sig_o : tb_bus;

  pattern_sequencer #(.ADDR_W(AW)) u_pattern_sequencer (
    .clk_i(clk), .rst_ni(rst_ni),
    .host_addr_i(host_addr), .host_we_i(host_we), .host_be_i(host_be),
    .host_wdata_i(host_wdata), .host_rdata_o(host_rdata_o),
    .end_addr_i(end_a), .sig_en_i(sig_en),
    .seq_rst_i(seq_rst), .seq_go_i(seq_go), .cyclic_i(cyc),
    .sink_rst_i(sink_rst), .sink_go_i(sink_go), .sink_trig_en_i(trig_en),
    .sink_data_i(sink_data), .sig_o(sig_o),
    .src_run_o(src_run_o), .sink_run_o(sink_run_o)
  );

  function automatic logic [7:0] pat_s(int i); return 8'((i * 37 + 5) & 255); endfunction
  function automatic logic [7:0] pat_k(int i); return 8'((i * 91 + 200) & 255); endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic hwrite(input int a, input logic [15:0] d, input logic [1:0] be);
    @(negedge clk);
    host_addr = AW'(a); host_wdata = d; host_be = be; host_we = 1'b1;
    @(negedge clk);
    host_we = 1'b0; host_be = 2'b00;
  endtask

  task automatic hread(input int a, output logic [15:0] d);
    @(negedge clk);
    host_addr = AW'(a);
    @(negedge clk);
    d = host_rdata_o;
  endtask

  task automatic verify_all(input string tag);
    logic [15:0] d;
    for (int a = 0; a < N; a++) begin
      hread(a, d);
      chk(tag, {16'h0, d}, {16'h0, snk_m[a], src_m[a]});
    end
  endtask

  task automatic run_src(input int e, input logic [7:0] en, input string tag);
    int k, first;
    k = 0; first = -1;
    end_a = AW'(e); sig_en = en;
    @(negedge clk);
    seq_go = 1'b1;
    for (int n = 1; n <= 40; n++) begin
      @(negedge clk);
      if (src_run_o) begin
        if (first < 0) first = n;
        chk({tag, " word"}, {24'h0, sig_o}, {24'h0, src_m[k % N] & en});
        k++;
      end
    end
    seq_go = 1'b0;
    chk({tag, " length"}, k, e + 1);
    chk({tag, " first word cycle"}, first, 2);
  endtask

  task automatic report;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not finish");
    report();
    $finish;
  end

  initial begin
    logic [15:0] d;
    int k, cs, cr;
    logic [7:0] v [5];

    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R3 reset src_run_o", {31'h0, src_run_o}, 0);
    chk("R7 reset sink_run_o", {31'h0, sink_run_o}, 0);
    chk("R8 reset sig_o", {24'h0, sig_o}, 0);

    // R1: fill and read back every word
    for (int i = 0; i < N; i++) begin
      src_m[i] = pat_s(i); snk_m[i] = pat_k(i);
      hwrite(i, {snk_m[i], src_m[i]}, 2'b11);
    end
    verify_all("R1 fill readback");

    // R1: byte enables
    hwrite(5, 16'hAB12, 2'b01); src_m[5] = 8'h12;
    hwrite(6, 16'hCD34, 2'b10); snk_m[6] = 8'hCD;
    hwrite(7, 16'hEF56, 2'b00);
    hread(5, d); chk("R1 be low only", {16'h0, d}, {16'h0, snk_m[5], src_m[5]});
    hread(6, d); chk("R1 be high only", {16'h0, d}, {16'h0, snk_m[6], src_m[6]});
    hread(7, d); chk("R1 be none", {16'h0, d}, {16'h0, snk_m[7], src_m[7]});

    // R3 / R6 one-shot at several end addresses, R8 enables
    run_src(0, 8'hFF, "R6 end0 R3");
    run_src(6, 8'hFF, "R3 end6");
    run_src(N - 1, 8'hFF, "R6 end max");
    run_src(9, 8'hA5, "R8 mask A5");
    run_src(3, 8'h00, "R8 mask none");
    for (int b = 0; b < 8; b++) run_src(2, 8'(1 << b), "R2 R8 single bit");

    // R4: go held high gives one run only
    end_a = 4'd2; sig_en = 8'hFF;
    @(negedge clk); seq_go = 1'b1;
    cs = 0;
    for (int n = 0; n < 60; n++) begin @(negedge clk); if (src_run_o) cs++; end
    chk("R4 held go one run", cs, 3);
    seq_go = 1'b0;

    // R4/R5: go raised under sequencer reset, still high after release
    @(negedge clk); seq_rst = 1'b1;
    @(negedge clk); seq_go = 1'b1;
    repeat (3) @(negedge clk);
    seq_rst = 1'b0;
    cs = 0;
    for (int n = 0; n < 20; n++) begin @(negedge clk); if (src_run_o) cs++; end
    chk("R4 go through reset ignored", cs, 0);
    seq_go = 1'b0;

    // R5: reset mid-run
    end_a = 4'd15;
    @(negedge clk); seq_go = 1'b1;
    repeat (5) @(negedge clk);
    chk("R5 running before reset", {31'h0, src_run_o}, 1);
    seq_rst = 1'b1;
    @(negedge clk);
    chk("R5 run cleared", {31'h0, src_run_o}, 0);
    chk("R5 sig cleared", {24'h0, sig_o}, 0);
    seq_rst = 1'b0; seq_go = 1'b0;
    cs = 0;
    for (int n = 0; n < 8; n++) begin @(negedge clk); if (src_run_o) cs++; end
    chk("R5 stays idle", cs, 0);

    // R6: cyclic wrap, then clear mode mid-run
    end_a = 4'd3; cyc = 1'b1; sig_en = 8'hFF;
    @(negedge clk); seq_go = 1'b1;
    k = 0;
    for (int n = 0; n < 60; n++) begin
      @(negedge clk);
      if (src_run_o) begin
        chk("R6 cyclic word", {24'h0, sig_o}, {24'h0, src_m[k % 4]});
        k++;
        if (k == 14) cyc = 1'b0;
      end
    end
    seq_go = 1'b0;
    chk("R6 cyclic stop on end word", k, 16);

    // R9: sink go with loopback
    end_a = 4'd7; sig_en = 8'h5A; loop_en = 1'b1;
    @(negedge clk); sink_go = 1'b1;
    cs = 0; cr = 0;
    for (int n = 0; n < 30; n++) begin
      @(negedge clk);
      if (src_run_o) cs++;
      if (sink_run_o) cr++;
    end
    sink_go = 1'b0; loop_en = 1'b0;
    chk("R9 source words", cs, 8);
    chk("R9 sink words", cr, 8);
    for (int i = 0; i <= 7; i++) snk_m[i] = src_m[i] & 8'h5A;
    verify_all("R9 loopback capture");

    // R10: no start without trigger bit or without arm
    end_a = 4'd4;
    trig_en = 1'b1; tb_bus = 8'hFE;
    cr = 0;
    for (int n = 0; n < 5; n++) begin @(negedge clk); if (sink_run_o) cr++; end
    trig_en = 1'b0; tb_bus = 8'h01;
    for (int n = 0; n < 5; n++) begin @(negedge clk); if (sink_run_o) cr++; end
    chk("R10 no start", cr, 0);
    tb_bus = 8'h00;

    // R10 trigger start with R11 host collision on index 0
    v[0] = 8'h31; v[1] = 8'h42; v[2] = 8'h53; v[3] = 8'h64; v[4] = 8'h75;
    @(negedge clk); trig_en = 1'b1;
    cr = 0;
    for (int j = 0; j < 9; j++) begin
      @(negedge clk);
      if (sink_run_o) cr++;
      tb_bus = (j < 5) ? v[j] : 8'h00;
      if (j == 1) begin
        host_addr = '0; host_wdata = 16'hEE77; host_be = 2'b11; host_we = 1'b1;
      end
      if (j == 2) begin host_we = 1'b0; host_be = 2'b00; end
      if (j == 5) trig_en = 1'b0;
    end
    chk("R10 sink_run cycles", cr, 5);
    for (int i = 0; i < 5; i++) snk_m[i] = v[i];
    src_m[0] = 8'h77;
    hread(0, d);
    chk("R11 capture wins high byte", {16'h0, d}, {16'h0, v[0], 8'h77});
    verify_all("R10 trigger capture");

    // R7: sink reset cuts a capture short, triggers ignored meanwhile
    end_a = 4'd10;
    @(negedge clk); trig_en = 1'b1;
    for (int j = 0; j < 10; j++) begin
      @(negedge clk);
      tb_bus = 8'(8'h81 + 2 * j);
      if (j == 3) sink_rst = 1'b1;
      if (j > 4) chk("R7 idle under sink reset", {31'h0, sink_run_o}, 0);
    end
    tb_bus = 8'h00; trig_en = 1'b0;
    @(negedge clk); sink_rst = 1'b0;
    snk_m[0] = 8'h81; snk_m[1] = 8'h83;
    verify_all("R7 truncated capture");

    // R12: main reset leaves memories intact
    @(negedge clk); rst_ni = 1'b0;
    repeat (2) @(negedge clk);
    chk("R12 reset src_run_o", {31'h0, src_run_o}, 0);
    chk("R12 reset sink_run_o", {31'h0, sink_run_o}, 0);
    rst_ni = 1'b1;
    verify_all("R12 memory kept");

    report();
    $finish;
  end
endmodule